// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block watches for a stalled processor. Software programs one 8-bit control byte with a 5-bit multiplier, a 2-bit resolution code and a steering bit. If no access to that byte arrives before the programmed interval ends, the timeout is sent to one of two places. It either raises a latched interrupt flag, or it drives a reset pulse of fixed length and then clears its own programming. A byte of zero turns the watchdog off.

Time advances only on `tick_slow`, a single-cycle enable that marks each sixteenth of a second. The resolution code sets how many of these ticks make one unit. The active-low interrupt line also carries a test square wave built from `tick_fast`. The watchdog has priority over that wave. The register port is synchronous: one-cycle read and write strobes, and read data that is valid in the strobe cycle.

The controller is a four-state machine. The states are `WS_OFF` (disabled), `WS_ARMED` (counting), `WS_IRQ` (flag latched) and `WS_PULSE` (reset pulse driven). Its transitions are:

- OFF→ARMED when the control byte becomes nonzero.
- ARMED→OFF when the byte is zero.
- ARMED→IRQ on a timeout with steering 0.
- ARMED→PULSE on a timeout with steering 1.
- IRQ→ARMED on any access to the control byte or a read of the flag byte.
- PULSE→ARMED or PULSE→OFF after the last pulse tick, chosen by whether the byte is nonzero.

Top module: `wdog_steer`

## Requirements
- R1: After reset the control byte reads 0x00, the flag is clear, and `irq_n` and `rst_out_n` are both high.
- R2: The control byte is laid out as follows: bit 7 is the steering bit, bits 6:2 are the multiplier M, and bits 1:0 are the resolution code. Codes 0, 1, 2 and 3 mean 1, 4, 16 and 64 `tick_slow` pulses per unit. A timeout occurs on the (M × unit)-th tick after arming or restart.
- R3: Any read or write of the control byte (address 0) restarts the interval from zero.
- R4: While the multiplier is zero (for example, after writing 0x00), no timeout ever occurs, whatever the steering bit holds.
- R5: A timeout with steering 0 sets `wd_flag` and drives `irq_n` low. Both stay that way until the flag byte (address 1) is read or the control byte is accessed.
- R6: A timeout with steering 1 drives `rst_out_n` low for PULSE_TICKS `tick_slow` pulses, and the flag stays clear. In the same cycle the control byte and the test-enable bit clear to 0.
- R7: The test wave is enabled when the test bit (address 2, bit 0) is 1, `alarm_irq_en` is 0, and either the steering bit is 1 or the control byte is 0x00. While it is enabled, `irq_n` is low in alternate `tick_fast` periods, so each `tick_fast` pulse toggles it.
- R8: While the watchdog is steered to the interrupt with a nonzero byte, the test wave is suppressed and `irq_n` stays high until a timeout.
- R9: Reads return the control byte at address 0, the flag in bit 7 of address 1, and the test bit in bit 0 of address 2. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | One-cycle enable, once per 1/16 s |
| tick_fast | input | 1 | One-cycle enable at twice the test-wave frequency |
| alarm_irq_en | input | 1 | Alarm interrupt enable from the neighbouring alarm logic; blocks the test wave |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 flag, 2 test |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_n | output | 1 | Active-low interrupt / test wave |
| rst_out_n | output | 1 | Active-low watchdog reset pulse |
| wd_flag | output | 1 | Watchdog timeout flag |

## Verification
The assertions assume the following about the inputs:

- Every strobe and tick lasts exactly one cycle.
- A write to the control byte is never followed in the next cycle by a `tick_slow`. The new value needs one cycle to arm the counter, and a tick in that cycle is not counted.

The stimulus meets these assumptions. It drives every input on the falling edge. Each task clears all strobes before it returns. Each control-byte write is followed by one idle cycle before any tick. The fast and slow ticks are also kept in separate cycles, so every expected edge can be counted exactly.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_ARMED = 2'd1,
        WS_IRQ   = 2'd2,
        WS_PULSE = 2'd3
    } wdg_state_e;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_FLAGS = 2'd1;
    localparam logic [1:0] RA_TEST  = 2'd2;

    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int UNIT_W = 7;

    // ticks per unit: 1, 4, 16, 64
    function automatic logic [UNIT_W-1:0] unit_ticks(input logic [RES_W-1:0] res);
        return UNIT_W'(1) << (2 * res);
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       self_clr,
    input  logic       wf,
    output logic [7:0] rdata,
    output logic [7:0] ctrl_q,
    output logic       test_q,
    output logic       ctrl_access,
    output logic       flags_rd
);

    assign ctrl_access = (wr_en || rd_en) && (addr == RA_CTRL);
    assign flags_rd    = rd_en && (addr == RA_FLAGS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            test_q <= 1'b0;
        end else begin
            if (self_clr) begin
                ctrl_q <= 8'h00;
                test_q <= 1'b0;
            end else if (wr_en) begin
                if (addr == RA_CTRL) ctrl_q <= wdata;
                if (addr == RA_TEST) test_q <= wdata[0];
            end
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL:  rdata = ctrl_q;
            RA_FLAGS: rdata = {wf, 7'b0};
            RA_TEST:  rdata = {7'b0, test_q};
            default:  rdata = 8'h00;
        endcase
    end

    // R6: a self-clear and a write in the same cycle leave the byte cleared
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        self_clr |=> (ctrl_q == 8'h00 && !test_q));

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int LIMIT_W = MULT_W + UNIT_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              restart,
    input  logic              tick,
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic              timeout
);

    logic [LIMIT_W-1:0] cnt;
    logic [LIMIT_W-1:0] limit;

    assign limit   = LIMIT_W'(mult) * LIMIT_W'(unit_ticks(res));
    assign timeout = armed && tick && !restart && (limit != '0)
                     && (cnt == limit - LIMIT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !armed || restart) cnt <= '0;
        else if (tick && !timeout)       cnt <= cnt + LIMIT_W'(1);
    end

    // R2: the count never reaches the programmed limit
    p_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && limit != '0) |-> (cnt < limit));

    // R3: an access leaves the count at zero in the next cycle
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
#(
    parameter int PULSE_TICKS = 2
)(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_nonzero,
    input  logic steer,
    input  logic timeout,
    input  logic tick,
    input  logic ctrl_access,
    input  logic flags_rd,
    output logic armed,
    output logic wf,
    output logic pulse_n,
    output logic self_clr
);

    localparam int PC_W = $clog2(PULSE_TICKS + 1);

    wdg_state_e state, nxt;
    logic [PC_W-1:0] pcnt;
    logic            pulse_done;

    assign pulse_done = tick && (pcnt == PC_W'(PULSE_TICKS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            WS_OFF:   if (ctrl_nonzero) nxt = WS_ARMED;
            WS_ARMED: if (!ctrl_nonzero) nxt = WS_OFF;
                      else if (timeout)  nxt = steer ? WS_PULSE : WS_IRQ;
            WS_IRQ:   if (ctrl_access || flags_rd) nxt = WS_ARMED;
            WS_PULSE: if (pulse_done) nxt = ctrl_nonzero ? WS_ARMED : WS_OFF;
            default:  nxt = WS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != WS_PULSE) pcnt <= '0;
        else if (tick)                   pcnt <= pcnt + PC_W'(1);
    end

    always_comb begin
        armed    = (state == WS_ARMED);
        wf       = (state == WS_IRQ);
        pulse_n  = (state != WS_PULSE);
        self_clr = (state == WS_ARMED) && ctrl_nonzero && timeout && steer;
    end

    // R5: the flag holds until an access clears it
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wf && !flags_rd && !ctrl_access) |=> wf);

    // R6: the pulse lasts until its tick count is reached
    p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_n && !tick) |=> !pulse_n);

    // R6: the flag stays clear while the reset pulse is active
    p_pulse_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wf && !pulse_n));

endmodule

// File: rtl/wdg_ftest.sv
module wdg_ftest (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_fast,
    input  logic enable,
    output logic wave
);

    logic sq;

    always_ff @(posedge clk) begin
        if (!rst_n)         sq <= 1'b0;
        else if (tick_fast) sq <= ~sq;
    end

    assign wave = enable && sq;

    // R7: the square wave only changes on a fast tick
    p_wave_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_fast |=> $stable(sq));

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdg_pkg::*;
#(
    parameter int PULSE_TICKS = 2
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_slow,
    input  logic       tick_fast,
    input  logic       alarm_irq_en,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_n,
    output logic       rst_out_n,
    output logic       wd_flag
);

    logic [7:0] ctrl_q;
    logic       test_q, ctrl_access, flags_rd;
    logic       armed, wf, pulse_n, self_clr, timeout;
    logic       steer, ctrl_nonzero, ft_en, ft_wave;

    assign steer        = ctrl_q[7];
    assign ctrl_nonzero = (ctrl_q != 8'h00);

    wdg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .self_clr(self_clr), .wf(wf),
        .rdata(reg_rdata), .ctrl_q(ctrl_q), .test_q(test_q),
        .ctrl_access(ctrl_access), .flags_rd(flags_rd)
    );

    wdg_timer u_timer (
        .clk(clk), .rst_n(rst_n), .armed(armed), .restart(ctrl_access),
        .tick(tick_slow), .mult(ctrl_q[6:2]), .res(ctrl_q[1:0]),
        .timeout(timeout)
    );

    wdg_ctrl #(.PULSE_TICKS(PULSE_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_nonzero(ctrl_nonzero), .steer(steer),
        .timeout(timeout), .tick(tick_slow), .ctrl_access(ctrl_access),
        .flags_rd(flags_rd), .armed(armed), .wf(wf), .pulse_n(pulse_n),
        .self_clr(self_clr)
    );

    assign ft_en = test_q && !alarm_irq_en && (steer || !ctrl_nonzero);

    wdg_ftest u_ftest (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast),
        .enable(ft_en), .wave(ft_wave)
    );

    assign irq_n     = !(wf || ft_wave);
    assign rst_out_n = pulse_n;
    assign wd_flag   = wf;

    // R6: the pulse starts with the byte and test bit already cleared
    p_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> (ctrl_q == 8'h00 && !test_q));

    // R8: a watchdog steered to the interrupt masks the test wave
    p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!steer && ctrl_nonzero && !wd_flag) |-> irq_n);

    // R4: a zero byte outside a pulse leaves the flag clear
    p_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 8'h00 && rst_out_n) |=> !wd_flag);

endmodule

// File: tb/wdog_steer_bench.sv
`timescale 1ns/1ps
module wdog_steer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_slow = 1'b0, tick_fast = 1'b0, alarm_irq_en = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n, rst_out_n, wd_flag;

    always #2.5 clk = ~clk;

    wdog_steer u_wdog_steer (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .alarm_irq_en(alarm_irq_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .rst_out_n(rst_out_n), .wd_flag(wd_flag)
    );

    typedef enum int {S_IRQ, S_RST, S_WF, S_RDATA} sig_e;
    typedef struct {
        sig_e       sig;
        logic [7:0] exp;
        string      req;
    } chk_t;

    chk_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // monitor: compares queued expectations just before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                chk_t c;
                logic [7:0] act;
                c = q.pop_front();
                unique case (c.sig)
                    S_IRQ:   act = {7'b0, irq_n};
                    S_RST:   act = {7'b0, rst_out_n};
                    S_WF:    act = {7'b0, wd_flag};
                    default: act = reg_rdata;
                endcase
                checks++;
                if (act !== c.exp) begin
                    errors++;
                    $display("FAIL %s sig=%0d actual=%h expected=%h", c.req, c.sig, act, c.exp);
                end
            end
        end
    end

    task automatic expect_val(input sig_e s, input logic [7:0] e, input string r);
        chk_t c;
        c.sig = s; c.exp = e; c.req = r;
        q.push_back(c);
    endtask

    task automatic clr();
        reg_wr = 0; reg_rd = 0; tick_slow = 0; tick_fast = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); clr(); end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); clr(); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); clr();
        @(negedge clk); clr();
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string r);
        @(negedge clk); clr(); reg_rd = 1; reg_addr = a;
        expect_val(S_RDATA, e, r);
        @(negedge clk); clr();
    endtask

    task automatic slow(input int n);
        repeat (n) begin
            @(negedge clk); clr(); tick_slow = 1;
            @(negedge clk); clr();
        end
    endtask

    task automatic fast();
        @(negedge clk); clr(); tick_fast = 1;
        @(negedge clk); clr();
    endtask

    task automatic run_timeout(input logic [7:0] d, input int n);
        wr(2'd0, d);
        slow(n - 1);
        expect_val(S_WF, 8'h00, "R2 before limit");
        slow(1);
        expect_val(S_WF, 8'h01, "R2 at limit");
        expect_val(S_IRQ, 8'h00, "R5 irq low");
        wr(2'd0, 8'h00);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        expect_val(S_IRQ, 8'h01, "R1 irq_n");
        expect_val(S_RST, 8'h01, "R1 rst_out_n");
        expect_val(S_WF, 8'h00, "R1 flag");
        rd(2'd0, 8'h00, "R1 ctrl byte");

        // R5 hold and clear through the flag byte, R9 flag readback
        wr(2'd0, 8'h04);
        slow(1);
        expect_val(S_WF, 8'h01, "R5 set");
        idle(5);
        expect_val(S_IRQ, 8'h00, "R5 hold");
        rd(2'd1, 8'h80, "R9 flag bit7");
        expect_val(S_WF, 8'h00, "R5 cleared by flag read");
        expect_val(S_IRQ, 8'h01, "R5 irq released");
        wr(2'd0, 8'h00);

        // R2 resolutions and multipliers
        run_timeout(8'h04, 1);
        run_timeout(8'h05, 4);
        run_timeout(8'h06, 16);
        run_timeout(8'h07, 64);
        run_timeout(8'h0D, 12);
        run_timeout(8'h0E, 48);

        // R3 restart by read, then by write; R5 clear by control access
        wr(2'd0, 8'h09);
        slow(5);
        rd(2'd0, 8'h09, "R9 ctrl readback");
        slow(7);
        expect_val(S_WF, 8'h00, "R3 read restarts");
        slow(1);
        expect_val(S_WF, 8'h01, "R3 timeout after read restart");
        wr(2'd0, 8'h09);
        expect_val(S_WF, 8'h00, "R5 cleared by control write");
        slow(5);
        wr(2'd0, 8'h09);
        slow(7);
        expect_val(S_WF, 8'h00, "R3 write restarts");
        slow(1);
        expect_val(S_WF, 8'h01, "R3 timeout after write restart");
        wr(2'd0, 8'h00);

        // R4 disabled with zero multiplier
        slow(70);
        expect_val(S_WF, 8'h00, "R4 zero byte");
        expect_val(S_IRQ, 8'h01, "R4 irq idle");
        wr(2'd0, 8'h80);
        slow(70);
        expect_val(S_RST, 8'h01, "R4 steer only");
        expect_val(S_WF, 8'h00, "R4 steer only flag");
        wr(2'd0, 8'h00);

        // R6 reset pulse and self-clear
        wr(2'd2, 8'h01);
        rd(2'd2, 8'h01, "R9 test bit");
        wr(2'd0, 8'h84);
        slow(1);
        expect_val(S_RST, 8'h00, "R6 pulse start");
        expect_val(S_WF, 8'h00, "R6 flag stays clear");
        rd(2'd0, 8'h00, "R6 ctrl cleared");
        rd(2'd2, 8'h00, "R6 test cleared");
        rd(2'd3, 8'h00, "R9 address 3");
        slow(1);
        expect_val(S_RST, 8'h00, "R6 pulse still low");
        slow(1);
        expect_val(S_RST, 8'h01, "R6 pulse end");

        // R7 test wave with zero byte
        wr(2'd2, 8'h01);
        fast();
        expect_val(S_IRQ, 8'h00, "R7 wave low phase");
        fast();
        expect_val(S_IRQ, 8'h01, "R7 wave high phase");
        alarm_irq_en = 1;
        fast();
        expect_val(S_IRQ, 8'h01, "R7 alarm enable blocks");
        fast();
        alarm_irq_en = 0;
        // R8 priority
        wr(2'd0, 8'h04);
        fast();
        expect_val(S_IRQ, 8'h01, "R8 suppressed");
        fast();
        expect_val(S_IRQ, 8'h01, "R8 suppressed again");
        wr(2'd0, 8'h84);
        fast();
        expect_val(S_IRQ, 8'h00, "R7 steer 1 enables");
        wr(2'd0, 8'h00);
        idle(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule